// File: doc/BRIEF.md
# Root Port Error Status Collector

This block sits at the receiving end of a root port's error reporting path. Each incoming error message carries a two-bit severity code and a 16-bit requester identifier. The block folds every message into a status register and two identifier fields. The status register holds received flags, multiple-message flags and a first-fatal marker. One identifier field keeps the first correctable source and the other keeps the first uncorrectable source. Software reads the status, clears flags by writing ones, and selects which classes may interrupt through a three-bit command register.

The interrupt output is a level signal with an edge-qualified rise. It goes high only when a message of an enabled class arrives while no enabled condition is already pending. It then stays high until every enabled pending condition is cleared or disabled. Enabling a class whose flag is already set does not raise the interrupt. A five-bit interrupt message number, supplied on an input, is reflected in the upper bits of the status word.

Top module: `root_err_collector`

## Requirements
- R1: After reset the status flags, both identifier fields, the command register and the interrupt output are zero.
- R2: A correctable message (severity code 0) sets the correctable-received flag (status bit 0). If that flag was already set, it sets the multiple-correctable flag (bit 1) and leaves the correctable identifier unchanged. Otherwise it stores the message identifier in the correctable identifier field.
- R3: A non-fatal message (severity code 1) sets the non-fatal-received flag (bit 5).
- R4: A fatal message (severity code 2) sets the fatal-received flag (bit 6). It also sets the first-fatal flag (bit 4) when the uncorrectable-received flag was clear beforehand.
- R5: A non-fatal or fatal message sets the uncorrectable-received flag (bit 2). If that flag was already set, it sets the multiple-uncorrectable flag (bit 3) and leaves the uncorrectable identifier unchanged. Otherwise it stores the message identifier in the uncorrectable identifier field.
- R6: A message with severity code 3 changes no status flag, identifier or interrupt.
- R7: The interrupt output goes high on the clock after a message whose class is enabled in the command register. Bit 0 enables correctable, bit 1 non-fatal and bit 2 fatal. This holds when none of the pending conditions (bits 0, 5, 6) was enabled before that message.
- R8: A message of a class whose command enable is clear records its status but does not raise the interrupt.
- R9: Once high, the interrupt stays high while at least one pending condition is enabled. It falls on the clock after the last one is cleared or disabled.
- R10: Writing ones to status bits 6..0 clears them. When a clear and a message fall in the same cycle, the clear applies first and the message is judged against the cleared value, so the message's flags survive.
- R11: Status bits 31..27 always show the interrupt message number input. Bits 26..7 read zero.
- R12: A message of an enabled class does not raise the interrupt when an enabled pending condition was already present, even if the interrupt was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Error message present this cycle |
| msg_sev | input | 2 | Severity: 0 correctable, 1 non-fatal, 2 fatal, 3 none |
| msg_src | input | 16 | Requester identifier of the message |
| cmd_we | input | 1 | Write strobe for the command register |
| cmd_wdata | input | 3 | New command value (bit0 cor, bit1 non-fatal, bit2 fatal) |
| sts_clr_we | input | 1 | Write-one-to-clear strobe for status |
| sts_clr_data | input | 7 | Ones mark status flags to clear |
| irq_msg_num | input | 5 | Interrupt message number shown in status |
| cmd_q | output | 3 | Command register |
| sts_q | output | 32 | Status word |
| cor_src_q | output | 16 | First correctable source identifier |
| unc_src_q | output | 16 | First uncorrectable source identifier |
| irq | output | 1 | Level interrupt |

## Verification
A software clear of the status flags and a new error message can land on the same clock, and their relative order decides both the flags and the captured identifier. The bench issues a full clear together with a correctable message, and then a clear of only the correctable flag together with another correctable message. It expects the received flag set without the multiple flag and the new identifier captured. The same scheme covers a command write and a message arriving together: the rise decision uses the command value held before that edge.

// File: rtl/rerr_pkg.sv
package rerr_pkg;
  localparam int FLAG_W = 7;
  localparam int B_COR  = 0;
  localparam int B_MCOR = 1;
  localparam int B_UNC  = 2;
  localparam int B_MUNC = 3;
  localparam int B_FF   = 4;
  localparam int B_NF   = 5;
  localparam int B_FT   = 6;

  localparam int CLS_COR = 0;
  localparam int CLS_NF  = 1;
  localparam int CLS_FT  = 2;
  localparam int CLS_W   = 3;

  typedef enum logic [1:0] {
    SEV_COR   = 2'd0,
    SEV_NF    = 2'd1,
    SEV_FATAL = 2'd2,
    SEV_NONE  = 2'd3
  } sev_e;

  // One bit per class, set for the class of a valid message.
  function automatic logic [CLS_W-1:0] sev_to_class(input logic valid, input logic [1:0] sev);
    logic [CLS_W-1:0] c;
    c = '0;
    if (valid) begin
      case (sev)
        SEV_COR:   c[CLS_COR] = 1'b1;
        SEV_NF:    c[CLS_NF]  = 1'b1;
        SEV_FATAL: c[CLS_FT]  = 1'b1;
        default:   c = '0;
      endcase
    end
    return c;
  endfunction

  // Flags after a message is merged into an already-cleared base.
  function automatic logic [FLAG_W-1:0] merge_flags(input logic [FLAG_W-1:0] base,
                                                   input logic [CLS_W-1:0] cls);
    logic [FLAG_W-1:0] f;
    f = base;
    if (cls[CLS_COR]) begin
      if (base[B_COR]) f[B_MCOR] = 1'b1;
      f[B_COR] = 1'b1;
    end
    if (cls[CLS_NF] || cls[CLS_FT]) begin
      if (cls[CLS_FT] && !base[B_UNC]) f[B_FF] = 1'b1;
      if (cls[CLS_FT]) f[B_FT] = 1'b1;
      if (cls[CLS_NF]) f[B_NF] = 1'b1;
      if (base[B_UNC]) f[B_MUNC] = 1'b1;
      f[B_UNC] = 1'b1;
    end
    return f;
  endfunction

  // Pending conditions, arranged in the bit order of the command register.
  function automatic logic [CLS_W-1:0] pending_of(input logic [FLAG_W-1:0] f);
    return {f[B_FT], f[B_NF], f[B_COR]};
  endfunction
endpackage

// File: rtl/rerr_msg_decode.sv
module rerr_msg_decode
  import rerr_pkg::*;
(
  input  logic             valid,
  input  logic [1:0]       sev,
  output logic [CLS_W-1:0] cls
);
  always_comb cls = sev_to_class(valid, sev);
endmodule

// File: rtl/rerr_status_upd.sv
module rerr_status_upd
  import rerr_pkg::*;
#(
  parameter int SRC_W = 16
) (
  input  logic [FLAG_W-1:0] flags_q,
  input  logic              clr_we,
  input  logic [FLAG_W-1:0] clr_data,
  input  logic [CLS_W-1:0]  cls,
  input  logic [SRC_W-1:0]  src,
  input  logic [SRC_W-1:0]  cor_src_q,
  input  logic [SRC_W-1:0]  unc_src_q,
  output logic [FLAG_W-1:0] base,
  output logic [FLAG_W-1:0] flags_d,
  output logic [SRC_W-1:0]  cor_src_d,
  output logic [SRC_W-1:0]  unc_src_d,
  output logic              cap_cor,
  output logic              cap_unc
);
  always_comb begin
    base    = clr_we ? (flags_q & ~clr_data) : flags_q;
    flags_d = merge_flags(base, cls);
    cap_cor = cls[CLS_COR] && !base[B_COR];
    cap_unc = (cls[CLS_NF] || cls[CLS_FT]) && !base[B_UNC];
    cor_src_d = cap_cor ? src : cor_src_q;
    unc_src_d = cap_unc ? src : unc_src_q;
  end
endmodule

// File: rtl/rerr_irq_gen.sv
module rerr_irq_gen
  import rerr_pkg::*;
(
  input  logic [FLAG_W-1:0] base,
  input  logic [FLAG_W-1:0] flags_d,
  input  logic [CLS_W-1:0]  cls,
  input  logic [CLS_W-1:0]  cmd_q,
  input  logic [CLS_W-1:0]  cmd_d,
  input  logic              irq_q,
  output logic              raise,
  output logic              irq_d
);
  logic prior_enabled;
  logic still_enabled;

  always_comb begin
    prior_enabled = |(pending_of(base) & cmd_q);
    still_enabled = |(pending_of(flags_d) & cmd_d);
    raise         = (|(cls & cmd_q)) && !prior_enabled;
    irq_d         = (raise || irq_q) && still_enabled;
  end
endmodule

// File: rtl/root_err_collector.sv
module root_err_collector
  import rerr_pkg::*;
#(
  parameter int SRC_W = 16,
  parameter int VEC_W = 5,
  parameter int STS_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_valid,
  input  logic [1:0]        msg_sev,
  input  logic [SRC_W-1:0]  msg_src,
  input  logic              cmd_we,
  input  logic [CLS_W-1:0]  cmd_wdata,
  input  logic              sts_clr_we,
  input  logic [FLAG_W-1:0] sts_clr_data,
  input  logic [VEC_W-1:0]  irq_msg_num,
  output logic [CLS_W-1:0]  cmd_q,
  output logic [STS_W-1:0]  sts_q,
  output logic [SRC_W-1:0]  cor_src_q,
  output logic [SRC_W-1:0]  unc_src_q,
  output logic              irq
);
  localparam int PAD_W = STS_W - VEC_W - FLAG_W;

  logic [CLS_W-1:0]  cls;
  logic [FLAG_W-1:0] flags_q;
  logic [FLAG_W-1:0] flags_d;
  logic [FLAG_W-1:0] base;
  logic [SRC_W-1:0]  cor_src_d;
  logic [SRC_W-1:0]  unc_src_d;
  logic [CLS_W-1:0]  cmd_d;
  logic              cap_cor;
  logic              cap_unc;
  logic              raise_evt;
  logic              irq_d;

  rerr_msg_decode u_dec (
    .valid (msg_valid),
    .sev   (msg_sev),
    .cls   (cls)
  );

  rerr_status_upd #(.SRC_W(SRC_W)) u_upd (
    .flags_q   (flags_q),
    .clr_we    (sts_clr_we),
    .clr_data  (sts_clr_data),
    .cls       (cls),
    .src       (msg_src),
    .cor_src_q (cor_src_q),
    .unc_src_q (unc_src_q),
    .base      (base),
    .flags_d   (flags_d),
    .cor_src_d (cor_src_d),
    .unc_src_d (unc_src_d),
    .cap_cor   (cap_cor),
    .cap_unc   (cap_unc)
  );

  assign cmd_d = cmd_we ? cmd_wdata : cmd_q;

  rerr_irq_gen u_irq (
    .base    (base),
    .flags_d (flags_d),
    .cls     (cls),
    .cmd_q   (cmd_q),
    .cmd_d   (cmd_d),
    .irq_q   (irq),
    .raise   (raise_evt),
    .irq_d   (irq_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q   <= '0;
      cor_src_q <= '0;
      unc_src_q <= '0;
      cmd_q     <= '0;
      irq       <= 1'b0;
    end else begin
      flags_q   <= flags_d;
      cor_src_q <= cor_src_d;
      unc_src_q <= unc_src_d;
      cmd_q     <= cmd_d;
      irq       <= irq_d;
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign sts_q = {irq_msg_num, {PAD_W{1'b0}}, flags_q};
    end else begin : g_nopad
      assign sts_q = {irq_msg_num, flags_q};
    end
  endgenerate
endmodule

// File: rtl/root_err_collector_chk.sv
module root_err_collector_chk
  import rerr_pkg::*;
#(
  parameter int SRC_W = 16,
  parameter int STS_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              msg_valid,
  input logic [1:0]        msg_sev,
  input logic              cmd_we,
  input logic              sts_clr_we,
  input logic [FLAG_W-1:0] sts_clr_data,
  input logic [CLS_W-1:0]  cmd_q,
  input logic [STS_W-1:0]  sts_q,
  input logic [SRC_W-1:0]  cor_src_q,
  input logic [SRC_W-1:0]  unc_src_q,
  input logic              irq,
  input logic              raise_evt
);
  // R9
  irq_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|({sts_q[B_FT], sts_q[B_NF], sts_q[B_COR]} & cmd_q)));

  // R7
  raise_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_evt && !cmd_we) |=> irq);

  // R2
  cor_src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q[B_COR] && !(sts_clr_we && sts_clr_data[B_COR])) |=> $stable(cor_src_q));

  // R5
  unc_src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q[B_UNC] && !(sts_clr_we && sts_clr_data[B_UNC])) |=> $stable(unc_src_q));

  // R6
  none_sev_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_sev == 2'd3 && !sts_clr_we && !cmd_we)
      |=> ($stable(sts_q[FLAG_W-1:0]) && $stable(irq)));

  // R4
  first_fatal_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[B_FF]) |-> $past(msg_valid && msg_sev == 2'd2));
endmodule

bind root_err_collector root_err_collector_chk #(.SRC_W(SRC_W), .STS_W(STS_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .msg_valid    (msg_valid),
  .msg_sev      (msg_sev),
  .cmd_we       (cmd_we),
  .sts_clr_we   (sts_clr_we),
  .sts_clr_data (sts_clr_data),
  .cmd_q        (cmd_q),
  .sts_q        (sts_q),
  .cor_src_q    (cor_src_q),
  .unc_src_q    (unc_src_q),
  .irq          (irq),
  .raise_evt    (raise_evt)
);

// File: tb/root_err_collector_tb.sv
module root_err_collector_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msg_valid = 1'b0;
  logic [1:0]  msg_sev = 2'd0;
  logic [15:0] msg_src = 16'h0;
  logic        cmd_we = 1'b0;
  logic [2:0]  cmd_wdata = 3'd0;
  logic        sts_clr_we = 1'b0;
  logic [6:0]  sts_clr_data = 7'd0;
  logic [4:0]  irq_msg_num = 5'd9;
  logic [2:0]  cmd_q;
  logic [31:0] sts_q;
  logic [15:0] cor_src_q;
  logic [15:0] unc_src_q;
  logic        irq;

  int n_checks = 0;
  int n_errors = 0;

  always #5 clk = ~clk;

  root_err_collector u_dut (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_sev(msg_sev),
    .msg_src(msg_src), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .sts_clr_we(sts_clr_we), .sts_clr_data(sts_clr_data),
    .irq_msg_num(irq_msg_num), .cmd_q(cmd_q), .sts_q(sts_q),
    .cor_src_q(cor_src_q), .unc_src_q(unc_src_q), .irq(irq)
  );

  typedef struct packed {
    logic [1:0]  sev;
    logic [15:0] src;
    logic [6:0]  flags;
    logic [15:0] cor;
    logic [15:0] unc;
    logic        irq;
  } vec_t;

  // Command = 3'b110 (non-fatal and fatal enabled) while walking this table.
  localparam vec_t VECS [5] = '{
    '{2'd0, 16'h1111, 7'h01, 16'h1111, 16'h0000, 1'b0},  // R2 R8 first correctable
    '{2'd0, 16'h2222, 7'h03, 16'h1111, 16'h0000, 1'b0},  // R2 repeat correctable
    '{2'd1, 16'h3333, 7'h27, 16'h1111, 16'h3333, 1'b1},  // R3 R5 R7 first non-fatal
    '{2'd2, 16'h4444, 7'h6F, 16'h1111, 16'h3333, 1'b1},  // R4 R5 R9 fatal after uncorrectable
    '{2'd3, 16'h5555, 7'h6F, 16'h1111, 16'h3333, 1'b1}   // R6 no-severity code
  };

  function automatic logic [31:0] sts_word(input logic [6:0] f);
    return {irq_msg_num, 20'd0, f};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycle(input logic v, input logic [1:0] s, input logic [15:0] src,
                       input logic cw, input logic [2:0] cd,
                       input logic clw, input logic [6:0] cld);
    @(negedge clk);
    msg_valid = v; msg_sev = s; msg_src = src;
    cmd_we = cw; cmd_wdata = cd; sts_clr_we = clw; sts_clr_data = cld;
    @(posedge clk);
    #1;
    msg_valid = 1'b0; cmd_we = 1'b0; sts_clr_we = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    chk("R1 sts", sts_q, sts_word(7'h00));
    chk("R1 cor", 32'(cor_src_q), 32'h0);
    chk("R1 unc", 32'(unc_src_q), 32'h0);
    chk("R1 cmd", 32'(cmd_q), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    // R11 message number reflected
    chk("R11 msgnum", 32'(sts_q[31:27]), 32'd9);

    cycle(1'b0, 2'd0, 16'h0, 1'b1, 3'b110, 1'b0, 7'h0);
    chk("R7 cmd write", 32'(cmd_q), 32'd6);

    for (int i = 0; i < 5; i++) begin
      cycle(1'b1, VECS[i].sev, VECS[i].src, 1'b0, 3'd0, 1'b0, 7'h0);
      chk("R2/R3/R4/R5/R6 table sts", sts_q, sts_word(VECS[i].flags));
      chk("R2 table cor", 32'(cor_src_q), 32'(VECS[i].cor));
      chk("R5 table unc", 32'(unc_src_q), 32'(VECS[i].unc));
      chk("R7/R8/R9 table irq", 32'(irq), 32'(VECS[i].irq));
    end

    // R10 R9 clear all flags drops irq
    cycle(1'b0, 2'd0, 16'h0, 1'b0, 3'd0, 1'b1, 7'h7F);
    chk("R10 clear sts", sts_q, sts_word(7'h00));
    chk("R9 irq falls after clear", 32'(irq), 32'h0);

    // R4 R5 R7 fatal with uncorrectable clear: first-fatal and fresh capture
    cycle(1'b1, 2'd2, 16'h6666, 1'b0, 3'd0, 1'b0, 7'h0);
    chk("R4 first fatal sts", sts_q, sts_word(7'h54));
    chk("R5 unc capture", 32'(unc_src_q), 32'h6666);
    chk("R7 irq raise", 32'(irq), 32'h1);

    // R9 disabling all classes drops irq, flags kept
    cycle(1'b0, 2'd0, 16'h0, 1'b1, 3'b000, 1'b0, 7'h0);
    chk("R9 irq falls on disable", 32'(irq), 32'h0);
    chk("R9 sts kept", sts_q, sts_word(7'h54));

    // R12 re-enable fatal: no message, no irq
    cycle(1'b0, 2'd0, 16'h0, 1'b1, 3'b100, 1'b0, 7'h0);
    chk("R12 enable alone no irq", 32'(irq), 32'h0);
    // R12 new fatal while enabled fatal pending: no rise
    cycle(1'b1, 2'd2, 16'h7777, 1'b0, 3'd0, 1'b0, 7'h0);
    chk("R12 no rise irq", 32'(irq), 32'h0);
    chk("R12 sts multi-unc", sts_q, sts_word(7'h5C));
    chk("R5 unc kept", 32'(unc_src_q), 32'h6666);

    // R10 clear all plus correctable message same cycle
    cycle(1'b1, 2'd0, 16'h8888, 1'b0, 3'd0, 1'b1, 7'h7F);
    chk("R10 same-cycle sts", sts_q, sts_word(7'h01));
    chk("R10 same-cycle cor", 32'(cor_src_q), 32'h8888);
    chk("R8 cor disabled irq", 32'(irq), 32'h0);

    // R10 clear only bit 0 with another correctable message
    cycle(1'b1, 2'd0, 16'h9999, 1'b0, 3'd0, 1'b1, 7'h01);
    chk("R10 partial clear sts", sts_q, sts_word(7'h01));
    chk("R10 partial clear cor", 32'(cor_src_q), 32'h9999);

    // R8 non-fatal with its enable clear
    cycle(1'b1, 2'd1, 16'hAAAA, 1'b0, 3'd0, 1'b0, 7'h0);
    chk("R8 nf disabled irq", 32'(irq), 32'h0);
    chk("R3 nf sts", sts_q, sts_word(7'h25));
    chk("R5 nf capture", 32'(unc_src_q), 32'hAAAA);

    // R11 message number follows its input
    @(negedge clk); irq_msg_num = 5'd22;
    #1;
    chk("R11 msgnum change", 32'(sts_q[31:27]), 32'd22);

    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule